// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

The mapper connects a fixed set of 75 peripheral request wires to a smaller, configurable number of DMA channels. Every request wire has its own 8-bit map register. Each map register holds an enable flag and the number of the target channel. Software programs these registers through a simple 32-bit register port. The map registers are split over two address windows: the first 64 wires in one window and the last 11 in a second window.

The request wires are asynchronous to the block. They pass through a synchronizer and are then merged per channel: a channel's request level is the OR of all enabled wires that point at it. The block registers each channel's level and watches it for edges. When a channel goes from idle to active, the block emits a one-cycle pulse that sets the channel's request-after-stop flag. When a channel goes from active to idle, the block emits one pulse that sets the channel's end-of-receive flag and another that clears its request-after-stop flag. The channel engines that consume these pulses are outside this block.

Top module: `req_chan_mapper`

## Requirements
- R1: After reset every map register reads 0, every channel request level is 0, and no event pulse is asserted.
- R2: Map register n, for n from 0 to 63, is at byte offset 0x100 + 4*n. Bit 7 is the enable flag and bits 4:0 are the target channel. A write stores the low byte, and a read returns that byte in bits 7:0 with zeros above it.
- R3: Map register n, for n from 64 to 74, is at byte offset 0x1100 + 4*(n-64). Offsets in that window past the last register (0x112C and up) read 0 and ignore writes.
- R4: Offsets 0xE0, 0xE4 and 0xE8 read 0. A write to them changes no map register.
- R5: A request wire whose map register has the enable flag at 0 has no effect on any channel output, whatever its channel field holds.
- R6: When a channel's merged request goes from 0 to 1, ch_req for that channel rises in the same cycle as a single-cycle ch_ras_set pulse. This happens on the third rising clock edge after the input change.
- R7: When a channel's merged request goes from 1 to 0, ch_req for that channel falls in the same cycle as single-cycle ch_eor_set and ch_ras_clr pulses.
- R8: A channel's request is the OR of all enabled wires mapped to it. A second wire rising while the channel is already active gives no ch_ras_set. One of two active wires falling gives no ch_eor_set.
- R9: A write with the enable flag at 1 and a channel field at or above NUM_CH is rejected: the map register keeps its old value and bus_err pulses in the cycle after the write. The same channel field with the enable flag at 0 is stored, and bus_err stays low.
- R10: Rewriting a map register while its wire is active moves the request. On the edge after the write, the old channel falls with its fall events and the new channel rises with ch_ras_set.
- R11: For a given channel, ch_ras_set and ch_eor_set are never asserted in the same cycle. A request that is high for only one cycle gives a rise event and then a fall event on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset of the register |
| bus_wdata | input | 32 | Write data; only bits 7:0 are stored |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| bus_err | output | 1 | One-cycle pulse after a rejected map write |
| req_in | input | 75 | Asynchronous peripheral request wires |
| ch_req | output | NUM_CH | Merged request level per channel |
| ch_ras_set | output | NUM_CH | Pulse: set request-after-stop flag |
| ch_ras_clr | output | NUM_CH | Pulse: clear request-after-stop flag |
| ch_eor_set | output | NUM_CH | Pulse: set end-of-receive flag |

## Verification
The bench targets the seams between the two map windows: the last slot of each window and the first address past the second window. A design that decoded a window wrongly would read the wrong byte or accept writes off the end of the map. It checks the sharing of one channel by two wires, where a design that used the latest wire instead of the OR would drop the level early or give a false end-of-receive. It checks a live remap, where a design that sampled the map late would leave the old channel asserted. It checks a request that is high for only one cycle, where a design that merged rise and fall would assert both flags together. It also checks a write of an out-of-range channel, where a lax design would store a channel number that does not exist.

// File: rtl/req_map_pkg.sv
package req_map_pkg;
  localparam int MAP_W   = 8;
  localparam int VLD_BIT = 7;
  localparam int CHF_W   = 5;
  typedef logic [MAP_W-1:0] map_t;
  typedef logic [CHF_W-1:0] chf_t;
endpackage

// File: rtl/req_sync.sv
module req_sync #(
  parameter int WIDTH  = 75,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = din;
    end else begin : g_next
      assign stg_d = stg[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg_d;
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/map_regfile.sv
module map_regfile
  import req_map_pkg::*;
#(
  parameter int          NUM_REQ    = 75,
  parameter int          NUM_CH     = 16,
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 32,
  parameter int          WIN_A_CNT  = 64,
  parameter logic [15:0] WIN_A_BASE = 16'h0100,
  parameter logic [15:0] WIN_B_BASE = 16'h1100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  map_t                  wr_byte,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  bus_err,
  output logic [NUM_REQ-1:0]    map_valid,
  output chf_t [NUM_REQ-1:0]    map_chan
);
  localparam int IDX_W     = $clog2(NUM_REQ);
  localparam int SLOT_W    = $clog2(WIN_A_CNT);
  localparam int PAGE_LSB  = SLOT_W + 2;
  localparam int WIN_B_CNT = NUM_REQ - WIN_A_CNT;

  map_t               map_q [NUM_REQ];
  logic [NUM_REQ-1:0] wr_en;
  logic [SLOT_W-1:0]  slot;
  logic               hit_a, hit_b, hit;
  logic [IDX_W-1:0]   idx;
  logic               field_bad, wr_go, err_d, err_q;

  always_comb begin
    slot  = bus_addr[SLOT_W+1:2];
    hit_a = (bus_addr[ADDR_W-1:PAGE_LSB] == WIN_A_BASE[ADDR_W-1:PAGE_LSB]) &&
            (bus_addr[1:0] == 2'b00);
    hit_b = (bus_addr[ADDR_W-1:PAGE_LSB] == WIN_B_BASE[ADDR_W-1:PAGE_LSB]) &&
            (bus_addr[1:0] == 2'b00) &&
            ({1'b0, slot} < (SLOT_W+1)'(WIN_B_CNT));
    hit   = hit_a | hit_b;
    idx   = hit_a ? IDX_W'(slot) : IDX_W'(slot) + IDX_W'(WIN_A_CNT);
    field_bad = wr_byte[VLD_BIT] &&
                ({1'b0, wr_byte[CHF_W-1:0]} >= (CHF_W+1)'(NUM_CH));
    wr_go = bus_sel & bus_we & hit;
    err_d = wr_go & field_bad;
    for (int i = 0; i < NUM_REQ; i++) begin
      wr_en[i] = wr_go & ~field_bad & (idx == IDX_W'(i));
    end
    bus_rdata = '0;
    if (bus_sel && !bus_we && hit) begin
      bus_rdata[MAP_W-1:0] = map_q[idx];
    end
  end

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        map_q[i] <= '0;
      else if (wr_en[i]) map_q[i] <= wr_byte;
    end
    assign map_valid[i] = map_q[i][VLD_BIT];
    assign map_chan[i]  = map_q[i][CHF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end
  assign bus_err = err_q;

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel && bus_we)); // R9

  AST_LOW_ADDR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr < WIN_A_BASE[ADDR_W-1:0]) |-> (bus_rdata == '0)); // R4
endmodule

// File: rtl/chan_route.sv
module chan_route
  import req_map_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_s,
  input  logic [NUM_REQ-1:0] map_valid,
  input  chf_t [NUM_REQ-1:0] map_chan,
  output logic [NUM_CH-1:0]  ch_req,
  output logic [NUM_CH-1:0]  ch_ras_set,
  output logic [NUM_CH-1:0]  ch_ras_clr,
  output logic [NUM_CH-1:0]  ch_eor_set
);
  logic [NUM_CH-1:0] lvl_d, lvl_q, rise_d, fall_d;
  logic [NUM_CH-1:0] rise_q, fall_q;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      lvl_d[c] = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        lvl_d[c] = lvl_d[c] | (req_s[r] & map_valid[r] & (map_chan[r] == CHF_W'(c)));
      end
    end
    rise_d = lvl_d & ~lvl_q;
    fall_d = ~lvl_d & lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign ch_req     = lvl_q;
  assign ch_ras_set = rise_q;
  assign ch_ras_clr = fall_q;
  assign ch_eor_set = fall_q;

  AST_RAS_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ras_set & ~(ch_req & ~$past(ch_req))) == '0); // R6

  AST_EOR_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_eor_set & ~(~ch_req & $past(ch_req))) == '0); // R7

  AST_RAS_CLR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ras_clr & ~(~ch_req & $past(ch_req))) == '0); // R7

  AST_ONE_EVENT_PER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ras_set & ch_eor_set) == '0); // R11
endmodule

// File: rtl/req_chan_mapper.sv
module req_chan_mapper
  import req_map_pkg::*;
#(
  parameter int NUM_REQ     = 75,
  parameter int NUM_CH      = 16,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_err,
  input  logic [NUM_REQ-1:0] req_in,
  output logic [NUM_CH-1:0]  ch_req,
  output logic [NUM_CH-1:0]  ch_ras_set,
  output logic [NUM_CH-1:0]  ch_ras_clr,
  output logic [NUM_CH-1:0]  ch_eor_set
);
  logic               rst_meta, rst_sync_n;
  logic [NUM_REQ-1:0] req_s;
  logic [NUM_REQ-1:0] map_valid;
  chf_t [NUM_REQ-1:0] map_chan;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:MAP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  req_sync #(.WIDTH(NUM_REQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  (req_in),
    .dout (req_s)
  );

  map_regfile #(
    .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wr_byte  (bus_wdata[MAP_W-1:0]),
    .bus_rdata(bus_rdata),
    .bus_err  (bus_err),
    .map_valid(map_valid),
    .map_chan (map_chan)
  );

  chan_route #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_s     (req_s),
    .map_valid (map_valid),
    .map_chan  (map_chan),
    .ch_req    (ch_req),
    .ch_ras_set(ch_ras_set),
    .ch_ras_clr(ch_ras_clr),
    .ch_eor_set(ch_eor_set)
  );
endmodule

// File: tb/req_chan_mapper_tb.sv
module req_chan_mapper_tb;
  localparam int NR = 75;
  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_err;
  logic [NR-1:0] req_in = '0;
  logic [NC-1:0] ch_req, ch_ras_set, ch_ras_clr, ch_eor_set;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  req_chan_mapper #(.NUM_CH(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .req_in(req_in), .ch_req(ch_req),
    .ch_ras_set(ch_ras_set), .ch_ras_clr(ch_ras_clr), .ch_eor_set(ch_eor_set)
  );

  // {req tag, addr, wdata, expected read, expected err}
  localparam logic [36:0] VEC [10] = '{
    {4'd2, 16'h0100, 8'h83, 8'h83, 1'b0},  // R2 req0 -> ch3
    {4'd2, 16'h01FC, 8'h8F, 8'h8F, 1'b0},  // R2 req63 -> ch15, last slot
    {4'd2, 16'h0150, 8'h83, 8'h83, 1'b0},  // R2 req20 -> ch3
    {4'd3, 16'h1100, 8'h81, 8'h81, 1'b0},  // R3 req64 -> ch1
    {4'd3, 16'h1128, 8'h85, 8'h85, 1'b0},  // R3 req74 -> ch5, last slot
    {4'd3, 16'h112C, 8'h81, 8'h00, 1'b0},  // R3 past the window end
    {4'd9, 16'h0104, 8'h9F, 8'h00, 1'b1},  // R9 enabled ch31 rejected
    {4'd9, 16'h0104, 8'h1F, 8'h1F, 1'b0},  // R9 disabled ch31 stored
    {4'd4, 16'h00E0, 8'hFF, 8'h00, 1'b0},  // R4 status reg
    {4'd4, 16'h00E8, 8'hFF, 8'h00, 1'b0}   // R4 status reg
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_ch(input string tag, input logic [NC-1:0] r, input logic [NC-1:0] rs,
                        input logic [NC-1:0] rc, input logic [NC-1:0] eo);
    chk({tag, " ch_req"}, 32'(ch_req), 32'(r));
    chk({tag, " ras_set"}, 32'(ch_ras_set), 32'(rs));
    chk({tag, " ras_clr"}, 32'(ch_ras_clr), 32'(rc));
    chk({tag, " eor_set"}, 32'(ch_eor_set), 32'(eo));
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input logic e, input string tag);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = {24'hA5A5A5, d};
    tick();
    bus_sel = 1'b0; bus_we = 1'b0;
    chk({tag, " bus_err"}, 32'(bus_err), 32'(e));
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    chk({tag, " rdata"}, bus_rdata, {24'h0, exp});
    bus_sel = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk_ch("R1 reset", '0, '0, '0, '0);
    bus_rd(16'h0100, 8'h00, "R1 map0");
    bus_rd(16'h1128, 8'h00, "R1 map74");
    tick();

    // R2 R3 R4 R9 table
    for (int i = 0; i < 10; i++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VEC[i][36:33], i);
      bus_wr(VEC[i][32:17], VEC[i][16:9], VEC[i][0], t);
      bus_rd(VEC[i][32:17], VEC[i][8:1], t);
      tick();
    end
    bus_rd(16'h0100, 8'h83, "R4 map0 untouched");
    tick();

    // R5 disabled (req1, field 31) and unmapped (req10) wires
    req_in[1] = 1'b1; req_in[10] = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk_ch("R5 ignored", '0, '0, '0, '0);
    end
    req_in[1] = 1'b0; req_in[10] = 1'b0;
    repeat (4) tick();

    // R6 rise on req0 -> ch3, third edge
    req_in[0] = 1'b1;
    tick(); chk_ch("R6 edge1", '0, '0, '0, '0);
    tick(); chk_ch("R6 edge2", '0, '0, '0, '0);
    tick(); chk_ch("R6 edge3", 16'h0008, 16'h0008, '0, '0);
    tick(); chk_ch("R6 edge4", 16'h0008, '0, '0, '0);

    // R8 second wire on ch3, then one falls
    req_in[20] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick(); chk_ch("R8 shared rise", 16'h0008, '0, '0, '0);
    end
    req_in[0] = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick(); chk_ch("R8 partial fall", 16'h0008, '0, '0, '0);
    end

    // R7 last wire falls
    req_in[20] = 1'b0;
    tick(); tick();
    chk_ch("R7 before", 16'h0008, '0, '0, '0);
    tick(); chk_ch("R7 fall", '0, '0, 16'h0008, 16'h0008);
    tick(); chk_ch("R7 after", '0, '0, '0, '0);

    // R11 one-cycle request on req74 -> ch5
    req_in[74] = 1'b1;
    tick();
    req_in[74] = 1'b0;
    tick(); chk_ch("R11 wait", '0, '0, '0, '0);
    tick(); chk_ch("R11 rise", 16'h0020, 16'h0020, '0, '0);
    tick(); chk_ch("R11 fall", '0, '0, 16'h0020, 16'h0020);
    tick(); chk_ch("R11 quiet", '0, '0, '0, '0);

    // R10 remap req64 from ch1 to ch2 while active
    req_in[64] = 1'b1;
    repeat (3) tick();
    chk_ch("R10 ch1 rise", 16'h0002, 16'h0002, '0, '0);
    tick();
    bus_wr(16'h1100, 8'h82, 1'b0, "R10 remap");
    chk_ch("R10 write edge", 16'h0002, '0, '0, '0);
    tick(); chk_ch("R10 moved", 16'h0004, 16'h0004, 16'h0002, 16'h0002);
    tick(); chk_ch("R10 settled", 16'h0004, '0, '0, '0);
    req_in[64] = 1'b0;
    repeat (4) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule